// File: doc/BRIEF.md
# Priority Group Request Arbiter

This block sits in front of a save/restore engine that walks descriptor groups around power transitions. It keeps track of which of 16 groups want a save or a restore, whether the request came from the power controller's hardware request lines or from a software trigger, and decides which single group the engine should run next. Each group carries a 4-bit save priority, a 4-bit restore priority and an enable bit. A global control input stops new hardware requests from being accepted.

When the engine is idle and at least one enabled group has exactly one direction pending, the arbiter launches the candidate with the numerically smallest priority for its direction, choosing the lower group number when priorities are equal. It then stays busy, holding the launched group and direction steady, until the engine reports completion. Completion clears the pending bits that took part in the launch and, if a software request was among them, produces a one-cycle done pulse. A group with both a save and a restore pending is flagged as a conflict and is never launched.

Top module: `grp_req_arbiter`

## Requirements
- R1: After reset all four pending vectors are zero, launchValid, busy and swDone are low, and conflict is zero.
- R2: A high bit g on hwSaveReq or hwRestoreReq at a clock edge sets bit g of hwSavePend or hwRestorePend, visible after that edge, when hwReqDisable is low; while hwReqDisable is high those inputs leave the hardware pending vectors unchanged.
- R3: A clock edge with swTrigValid high sets bit swTrigGroup of swSavePend when swTrigRestore is 0, or of swRestorePend when swTrigRestore is 1, regardless of the group's enable.
- R4: Among enabled groups with one direction pending, the launch picks the smallest priority value (0 is the highest), taken from savePrio for a save and restorePrio for a restore; group g's field is bits [4g+3:4g] of each vector.
- R5: Candidates with equal priority are launched in ascending group number.
- R6: A group whose grpEnable bit is low is never launched and keeps its pending bits; once enabled again it competes normally.
- R7: A group that is enabled and has both a save (either source) and a restore (either source) pending shows a 1 in conflict and is not launched, while other groups still are.
- R8: A launch is a one-cycle launchValid pulse on the edge after the candidate becomes visible while idle; busy rises with it, and launchGroup and launchRestore (1 = restore) hold the launched group and direction until completion.
- R9: While busy no further launch happens, whatever the priority of newly pending groups; engineDone while idle has no effect.
- R10: engineDone while busy ends the run on that edge, clears the launched group's pending bits of the launched direction for the sources that were pending at launch, and pulses swDone for one cycle after that edge exactly when a software request was among them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hwSaveReq | input | 16 | Hardware save request per group |
| hwRestoreReq | input | 16 | Hardware restore request per group |
| hwReqDisable | input | 1 | Blocks acceptance of hardware requests |
| swTrigValid | input | 1 | Software trigger strobe |
| swTrigGroup | input | 4 | Group addressed by the software trigger |
| swTrigRestore | input | 1 | Software trigger direction, 1 = restore |
| grpEnable | input | 16 | Per-group arbitration enable |
| savePrio | input | 64 | Packed 4-bit save priorities, group g at [4g+3:4g] |
| restorePrio | input | 64 | Packed 4-bit restore priorities, group g at [4g+3:4g] |
| engineDone | input | 1 | Engine completion strobe for the running group |
| launchValid | output | 1 | One-cycle launch pulse |
| launchGroup | output | 4 | Launched group number |
| launchRestore | output | 1 | Launched direction, 1 = restore |
| busy | output | 1 | A launched group is running |
| swDone | output | 1 | A software-requested run completed |
| conflict | output | 16 | Groups with save and restore both pending |
| hwSavePend | output | 16 | Hardware save pending vector |
| hwRestorePend | output | 16 | Hardware restore pending vector |
| swSavePend | output | 16 | Software save pending vector |
| swRestorePend | output | 16 | Software restore pending vector |

## Verification
Several groups are raised on the same edge with equal priorities, then with skewed save priorities, then with a restore and a save at different priorities, so that index tie-breaking, priority ordering and per-direction priority selection each show up as a distinct launch order in the scoreboard. A disabled group, a disabled hardware path and a stray completion while idle are each followed by a check of the pending vectors and busy, separating "held" from "dropped" and "ignored". A long-running low-priority group with a top-priority request arriving behind it shows the absence of pre-emption, and a save/restore clash on one group next to a clean request on another shows that the conflict blocks only its own group.

// File: rtl/grp_arb_pkg.sv
package grp_arb_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic launch;  // capture the current winner and start a run
    logic finish;  // the running group completed: retire its requests
  } ctrlStb_t;

endpackage

// File: rtl/grp_arb_datapath.sv
module grp_arb_datapath
  import grp_arb_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int PRIO_W     = 4,
  localparam int IDX_W     = $clog2(NUM_GROUPS),
  localparam int PVEC_W    = NUM_GROUPS * PRIO_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_GROUPS-1:0] hwSaveReq,
  input  logic [NUM_GROUPS-1:0] hwRestoreReq,
  input  logic                  hwReqDisable,
  input  logic                  swTrigValid,
  input  logic [IDX_W-1:0]      swTrigGroup,
  input  logic                  swTrigRestore,
  input  logic [NUM_GROUPS-1:0] grpEnable,
  input  logic [PVEC_W-1:0]     savePrio,
  input  logic [PVEC_W-1:0]     restorePrio,
  input  ctrlStb_t              stb,
  output logic                  anyEligible,
  output logic [NUM_GROUPS-1:0] conflict,
  output logic [NUM_GROUPS-1:0] hwSavePend,
  output logic [NUM_GROUPS-1:0] hwRestorePend,
  output logic [NUM_GROUPS-1:0] swSavePend,
  output logic [NUM_GROUPS-1:0] swRestorePend,
  output logic [IDX_W-1:0]      runGroup,
  output logic                  runRestore,
  output logic                  swDone
);

  localparam logic [NUM_GROUPS-1:0] ONE_HOT0 = NUM_GROUPS'(1);

  logic [NUM_GROUPS-1:0] hwSavePendQ, hwRestorePendQ;
  logic [NUM_GROUPS-1:0] swSavePendQ, swRestorePendQ;
  logic [NUM_GROUPS-1:0] savePendAny, restorePendAny, eligible;
  logic [PRIO_W-1:0]     candPrio [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] candRestore;

  logic                  winValid;
  logic [IDX_W-1:0]      winGroup;
  logic [PRIO_W-1:0]     winPrio;
  logic                  winRestore;

  logic                  runHw, runSw, swDoneQ;
  logic [IDX_W-1:0]      runGroupQ;
  logic                  runRestoreQ;

  // ---------------- request set / clear masks ----------------
  logic [NUM_GROUPS-1:0] hwSaveSet, hwRestoreSet, swSaveSet, swRestoreSet;
  logic [NUM_GROUPS-1:0] runMask;
  logic [NUM_GROUPS-1:0] hwSaveClr, hwRestoreClr, swSaveClr, swRestoreClr;
  logic [NUM_GROUPS-1:0] swSel;

  always_comb begin
    hwSaveSet    = hwReqDisable ? '0 : hwSaveReq;
    hwRestoreSet = hwReqDisable ? '0 : hwRestoreReq;
    swSel        = swTrigValid ? (ONE_HOT0 << swTrigGroup) : '0;
    swSaveSet    = swTrigRestore ? '0 : swSel;
    swRestoreSet = swTrigRestore ? swSel : '0;

    runMask      = stb.finish ? (ONE_HOT0 << runGroupQ) : '0;
    hwSaveClr    = (runHw && !runRestoreQ) ? runMask : '0;
    hwRestoreClr = (runHw &&  runRestoreQ) ? runMask : '0;
    swSaveClr    = (runSw && !runRestoreQ) ? runMask : '0;
    swRestoreClr = (runSw &&  runRestoreQ) ? runMask : '0;
  end

  // New requests win over a clear on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwSavePendQ    <= '0;
      hwRestorePendQ <= '0;
      swSavePendQ    <= '0;
      swRestorePendQ <= '0;
    end else begin
      hwSavePendQ    <= (hwSavePendQ    & ~hwSaveClr)    | hwSaveSet;
      hwRestorePendQ <= (hwRestorePendQ & ~hwRestoreClr) | hwRestoreSet;
      swSavePendQ    <= (swSavePendQ    & ~swSaveClr)    | swSaveSet;
      swRestorePendQ <= (swRestorePendQ & ~swRestoreClr) | swRestoreSet;
    end
  end

  // ---------------- eligibility and per-group key ----------------
  assign savePendAny    = hwSavePendQ | swSavePendQ;
  assign restorePendAny = hwRestorePendQ | swRestorePendQ;
  assign conflict       = grpEnable & savePendAny & restorePendAny;
  assign eligible       = grpEnable & (savePendAny ^ restorePendAny);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_key
    assign candRestore[g] = restorePendAny[g];
    assign candPrio[g]    = restorePendAny[g] ? restorePrio[g*PRIO_W +: PRIO_W]
                                              : savePrio[g*PRIO_W +: PRIO_W];
  end

  // Minimum search; strict compare keeps the lowest index on a tie.
  always_comb begin
    winValid   = 1'b0;
    winGroup   = '0;
    winPrio    = '1;
    winRestore = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (eligible[g] && (!winValid || (candPrio[g] < winPrio))) begin
        winValid   = 1'b1;
        winGroup   = IDX_W'(g);
        winPrio    = candPrio[g];
        winRestore = candRestore[g];
      end
    end
  end

  assign anyEligible = winValid;

  // ---------------- running group capture ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runGroupQ   <= '0;
      runRestoreQ <= 1'b0;
      runHw       <= 1'b0;
      runSw       <= 1'b0;
      swDoneQ     <= 1'b0;
    end else begin
      swDoneQ <= stb.finish && runSw;
      if (stb.launch) begin
        runGroupQ   <= winGroup;
        runRestoreQ <= winRestore;
        runHw       <= winRestore ? hwRestorePendQ[winGroup] : hwSavePendQ[winGroup];
        runSw       <= winRestore ? swRestorePendQ[winGroup] : swSavePendQ[winGroup];
      end
    end
  end

  assign hwSavePend    = hwSavePendQ;
  assign hwRestorePend = hwRestorePendQ;
  assign swSavePend    = swSavePendQ;
  assign swRestorePend = swRestorePendQ;
  assign runGroup      = runGroupQ;
  assign runRestore    = runRestoreQ;
  assign swDone        = swDoneQ;

  // ---------------- assertions ----------------
  // R2
  hw_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwReqDisable |=> (((hwSavePendQ & ~$past(hwSavePendQ)) == '0) &&
                      ((hwRestorePendQ & ~$past(hwRestorePendQ)) == '0)));

  // R3
  sw_save_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swTrigValid && !swTrigRestore) |=> swSavePendQ[$past(swTrigGroup)]);

  // R6
  launch_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |-> grpEnable[winGroup]);

  // R7
  launch_no_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |-> !conflict[winGroup]);

  // R10
  sw_done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    swDoneQ |-> $past(stb.finish));

endmodule

// File: rtl/grp_arb_control.sv
module grp_arb_control
  import grp_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyEligible,
  input  logic     engineDone,
  output ctrlStb_t stb,
  output logic     launchValid,
  output logic     busy
);

  typedef enum logic {ST_IDLE, ST_RUN} runState_t;

  runState_t state;
  logic      launchQ;

  // Arbitration only acts while idle, so a run is never pre-empted.
  always_comb begin
    stb.launch = (state == ST_IDLE) && anyEligible;
    stb.finish = (state == ST_RUN) && engineDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      launchQ <= 1'b0;
    end else begin
      launchQ <= stb.launch;
      case (state)
        ST_IDLE: if (stb.launch) state <= ST_RUN;
        ST_RUN:  if (stb.finish) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign launchValid = launchQ;
  assign busy        = (state == ST_RUN);

  // R8
  launch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    launchValid |=> !launchValid);

  // R8
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    launchValid |-> busy);

  // R9
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !engineDone) |=> (busy && !launchValid));

  // R9
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyEligible) |=> !busy);

endmodule

// File: rtl/grp_req_arbiter.sv
module grp_req_arbiter
  import grp_arb_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int PRIO_W     = 4,
  localparam int IDX_W     = $clog2(NUM_GROUPS),
  localparam int PVEC_W    = NUM_GROUPS * PRIO_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_GROUPS-1:0] hwSaveReq,
  input  logic [NUM_GROUPS-1:0] hwRestoreReq,
  input  logic                  hwReqDisable,
  input  logic                  swTrigValid,
  input  logic [IDX_W-1:0]      swTrigGroup,
  input  logic                  swTrigRestore,
  input  logic [NUM_GROUPS-1:0] grpEnable,
  input  logic [PVEC_W-1:0]     savePrio,
  input  logic [PVEC_W-1:0]     restorePrio,
  input  logic                  engineDone,
  output logic                  launchValid,
  output logic [IDX_W-1:0]      launchGroup,
  output logic                  launchRestore,
  output logic                  busy,
  output logic                  swDone,
  output logic [NUM_GROUPS-1:0] conflict,
  output logic [NUM_GROUPS-1:0] hwSavePend,
  output logic [NUM_GROUPS-1:0] hwRestorePend,
  output logic [NUM_GROUPS-1:0] swSavePend,
  output logic [NUM_GROUPS-1:0] swRestorePend
);

  ctrlStb_t stb;
  logic     anyEligible;

  grp_arb_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .anyEligible (anyEligible),
    .engineDone  (engineDone),
    .stb         (stb),
    .launchValid (launchValid),
    .busy        (busy)
  );

  grp_arb_datapath #(
    .NUM_GROUPS (NUM_GROUPS),
    .PRIO_W     (PRIO_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .hwSaveReq     (hwSaveReq),
    .hwRestoreReq  (hwRestoreReq),
    .hwReqDisable  (hwReqDisable),
    .swTrigValid   (swTrigValid),
    .swTrigGroup   (swTrigGroup),
    .swTrigRestore (swTrigRestore),
    .grpEnable     (grpEnable),
    .savePrio      (savePrio),
    .restorePrio   (restorePrio),
    .stb           (stb),
    .anyEligible   (anyEligible),
    .conflict      (conflict),
    .hwSavePend    (hwSavePend),
    .hwRestorePend (hwRestorePend),
    .swSavePend    (swSavePend),
    .swRestorePend (swRestorePend),
    .runGroup      (launchGroup),
    .runRestore    (launchRestore),
    .swDone        (swDone)
  );

  // R8
  hold_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !launchValid) |-> ($stable(launchGroup) && $stable(launchRestore)));

endmodule

// File: tb/sim_grp_req_arbiter.sv
module sim_grp_req_arbiter;

  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  hwSaveReq = '0, hwRestoreReq = '0;
  logic          hwReqDisable = 1'b0;
  logic          swTrigValid = 1'b0;
  logic [3:0]    swTrigGroup = '0;
  logic          swTrigRestore = 1'b0;
  logic [N-1:0]  grpEnable = '1;
  logic [4*N-1:0] savePrio, restorePrio;
  logic          engineDone;
  logic          launchValid, launchRestore, busy, swDone;
  logic [3:0]    launchGroup;
  logic [N-1:0]  conflict, hwSavePend, hwRestorePend, swSavePend, swRestorePend;

  logic [3:0] sPr [N];
  logic [3:0] rPr [N];

  always_comb begin
    for (int g = 0; g < N; g++) begin
      savePrio[g*4 +: 4]    = sPr[g];
      restorePrio[g*4 +: 4] = rPr[g];
    end
  end

  always #2 clk = ~clk;  // 250 MHz

  grp_req_arbiter u0 (
    .clk(clk), .rstN(rstN),
    .hwSaveReq(hwSaveReq), .hwRestoreReq(hwRestoreReq), .hwReqDisable(hwReqDisable),
    .swTrigValid(swTrigValid), .swTrigGroup(swTrigGroup), .swTrigRestore(swTrigRestore),
    .grpEnable(grpEnable), .savePrio(savePrio), .restorePrio(restorePrio),
    .engineDone(engineDone),
    .launchValid(launchValid), .launchGroup(launchGroup), .launchRestore(launchRestore),
    .busy(busy), .swDone(swDone), .conflict(conflict),
    .hwSavePend(hwSavePend), .hwRestorePend(hwRestorePend),
    .swSavePend(swSavePend), .swRestorePend(swRestorePend)
  );

  int errs = 0;
  int checks = 0;
  int swDoneCnt = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- engine model ----------------
  int  engLat = 3;
  int  engCnt = 0;
  logic engDone = 1'b0;
  logic strayDone = 1'b0;
  assign engineDone = engDone | strayDone;

  always @(negedge clk) begin
    if (engDone) begin
      engDone = 1'b0;
      engCnt  = 0;
    end else if (busy) begin
      engCnt++;
      if (engCnt >= engLat) engDone = 1'b1;
    end else begin
      engCnt = 0;
    end
  end

  // ---------------- scoreboard ----------------
  logic [4:0] expQ[$];
  string      expReq[$];

  task automatic expectLaunch(input int grp, input bit rst, input string req);
    expQ.push_back({rst, 4'(grp)});
    expReq.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rstN && launchValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9", "unexpected launch group", int'(launchGroup), -1);
      end else begin
        logic [4:0] e;
        string r;
        e = expQ.pop_front();
        r = expReq.pop_front();
        chk({launchRestore, launchGroup} == e, r, "launch {restore,group}",
            int'({launchRestore, launchGroup}), int'(e));
      end
    end
    if (rstN && swDone) swDoneCnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    for (int g = 0; g < N; g++) begin sPr[g] = 4'd8; rPr[g] = 4'd8; end
    tick(3);
    // R1 during reset
    chk({hwSavePend, hwRestorePend, swSavePend, swRestorePend} == '0, "R1", "pending in reset", 0, 0);
    chk(!launchValid && !busy && !swDone && conflict == '0, "R1", "outputs in reset", int'(busy), 0);
    rstN = 1'b1;
    tick(2);
    chk(!busy && !launchValid, "R1", "idle after reset", int'(busy), 0);

    // R2 / R8: single hardware save
    expectLaunch(5, 1'b0, "R8");
    hwSaveReq[5] = 1'b1;
    tick(1);
    hwSaveReq = '0;
    chk(hwSavePend == 16'h0020, "R2", "hwSavePend after request", int'(hwSavePend), 32);
    chk(!launchValid, "R8", "no launch before next edge", int'(launchValid), 0);
    tick(1);
    chk(launchValid && busy && launchGroup == 4'd5, "R8", "launch group", int'(launchGroup), 5);
    tick(1);
    chk(!launchValid && busy && launchGroup == 4'd5, "R8", "hold while busy", int'(launchGroup), 5);
    tick(10);
    chk(hwSavePend == '0 && !busy, "R10", "hwSavePend after done", int'(hwSavePend), 0);
    chk(swDoneCnt == 0, "R10", "no swDone for hw run", swDoneCnt, 0);

    // R5: equal priorities, ascending index
    expectLaunch(3, 1'b0, "R5");
    expectLaunch(9, 1'b0, "R5");
    expectLaunch(12, 1'b0, "R5");
    hwSaveReq = 16'h1208;
    tick(1);
    hwSaveReq = '0;
    tick(40);

    // R4: save priorities decide
    sPr[9] = 4'd2; sPr[3] = 4'd7; sPr[12] = 4'd7;
    expectLaunch(9, 1'b0, "R4");
    expectLaunch(3, 1'b0, "R4");
    expectLaunch(12, 1'b0, "R4");
    hwSaveReq = 16'h1208;
    tick(1);
    hwSaveReq = '0;
    tick(40);

    // R4: restore priority of one group against save priority of another
    rPr[4] = 4'd1; sPr[2] = 4'd5; sPr[4] = 4'd0;
    expectLaunch(4, 1'b1, "R4");
    expectLaunch(2, 1'b0, "R4");
    hwRestoreReq[4] = 1'b1;
    hwSaveReq[2] = 1'b1;
    tick(1);
    hwRestoreReq = '0; hwSaveReq = '0;
    tick(30);
    chk(hwRestorePend == '0 && hwSavePend == '0, "R10", "pending cleared", int'(hwRestorePend), 0);

    // R6: disabled group held, not launched
    grpEnable[6] = 1'b0;
    hwSaveReq[6] = 1'b1;
    tick(1);
    hwSaveReq = '0;
    tick(6);
    chk(!busy, "R6", "disabled group not launched", int'(busy), 0);
    chk(hwSavePend[6], "R6", "pending retained", int'(hwSavePend[6]), 1);
    // R9: stray completion while idle
    strayDone = 1'b1;
    tick(1);
    strayDone = 1'b0;
    tick(2);
    chk(hwSavePend == 16'h0040 && !busy, "R9", "idle engineDone ignored", int'(hwSavePend), 64);
    expectLaunch(6, 1'b0, "R6");
    grpEnable[6] = 1'b1;
    tick(20);
    chk(hwSavePend == '0, "R6", "launched after re-enable", int'(hwSavePend), 0);

    // R2: hardware requests blocked
    hwReqDisable = 1'b1;
    hwSaveReq[7] = 1'b1;
    hwRestoreReq[1] = 1'b1;
    tick(1);
    hwSaveReq = '0; hwRestoreReq = '0;
    chk(hwSavePend == '0 && hwRestorePend == '0, "R2", "disabled hw request", int'(hwSavePend), 0);
    tick(5);
    chk(!busy, "R2", "no launch from blocked request", int'(busy), 0);
    hwReqDisable = 1'b0;

    // R3 / R10: software triggers
    expectLaunch(11, 1'b1, "R3");
    swTrigValid = 1'b1; swTrigGroup = 4'd11; swTrigRestore = 1'b1;
    tick(1);
    swTrigValid = 1'b0;
    chk(swRestorePend == 16'h0800, "R3", "swRestorePend", int'(swRestorePend), 2048);
    tick(20);
    chk(swDoneCnt == 1, "R10", "swDone pulses after sw restore", swDoneCnt, 1);
    chk(swRestorePend == '0, "R10", "swRestorePend cleared", int'(swRestorePend), 0);
    expectLaunch(0, 1'b0, "R3");
    swTrigValid = 1'b1; swTrigGroup = 4'd0; swTrigRestore = 1'b0;
    tick(1);
    swTrigValid = 1'b0;
    chk(swSavePend == 16'h0001, "R3", "swSavePend", int'(swSavePend), 1);
    tick(20);
    chk(swDoneCnt == 2 && swSavePend == '0, "R10", "swDone after sw save", swDoneCnt, 2);

    // R9: no pre-emption by a higher priority request
    sPr[15] = 4'd15; sPr[0] = 4'd0;
    engLat = 20;
    expectLaunch(15, 1'b0, "R9");
    expectLaunch(0, 1'b0, "R9");
    hwSaveReq[15] = 1'b1;
    tick(1);
    hwSaveReq = '0;
    tick(2);
    hwSaveReq[0] = 1'b1;
    tick(1);
    hwSaveReq = '0;
    tick(5);
    chk(busy && launchGroup == 4'd15, "R9", "running group kept", int'(launchGroup), 15);
    tick(60);
    engLat = 3;

    // R7: conflict blocks only its own group
    expectLaunch(10, 1'b0, "R7");
    hwSaveReq[8] = 1'b1;
    hwSaveReq[10] = 1'b1;
    swTrigValid = 1'b1; swTrigGroup = 4'd8; swTrigRestore = 1'b1;
    tick(1);
    hwSaveReq = '0; swTrigValid = 1'b0;
    chk(conflict == 16'h0100, "R7", "conflict vector", int'(conflict), 256);
    tick(20);
    chk(!busy && hwSavePend == 16'h0100 && swRestorePend == 16'h0100, "R7",
        "conflicting group left pending", int'(hwSavePend), 256);
    grpEnable[8] = 1'b0;
    tick(1);
    chk(conflict == '0, "R7", "conflict needs enable", int'(conflict), 0);
    tick(5);

    chk(expQ.size() == 0, "R8", "expected launches outstanding", expQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule